// File: doc/BRIEF.md
# Exhaustive PLL Ratio Search Engine

This block picks a multiplier and a divider for a frequency synthesiser. Software or a sequencer supplies a reference frequency and a wanted output frequency, both in hertz, and pulses `start`. The engine then tries every multiplier/divider pair in a fixed order. Each pair is scored by how far its nominal output, the multiplier times the integer quotient of reference over divider, lands from the wanted frequency. The engine keeps the first pair with the smallest error.

First the engine fills a small memory with the quotient for every divider, using a shift-and-subtract divider, so the scan itself needs no divider. The scan then scores one candidate per clock. It stops at once when a candidate hits the target exactly. The result appears as separate multiplier, divider and residual error fields, and also as a packed word that can be written straight into a PLL configuration register. Programming the PLL and waiting for lock are left to the caller.

Top module: `pll_ratio_search`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0, `best_mul` is 1, `best_div` is 1, `best_err` is 0 and `cfg_word` is 256.
- R2: The multiplier runs from 1 to 2^MUL_W-1 in the outer loop and the divider from 1 to 2^DIV_W-1 in the inner loop. The largest multiplier and the largest divider can both be chosen.
- R3: A candidate's error is |target - mul × floor(ref / div)|, computed at full width. Products above 2^FREQ_W are not truncated.
- R4: The best error starts equal to the target. A candidate replaces the current best only if its error is strictly smaller, so on a tie the candidate earlier in scan order is kept.
- R5: The scan ends as soon as a candidate has zero error. The reported result is that candidate.
- R6: If no candidate beats the starting error, the result is multiplier 1 and divider 1, with `best_err` equal to the target.
- R7: `cfg_word` equals (best_mul << 8) | (best_div - 1). The divider field sits in bits 7:0 and the multiplier field starts at bit 8.
- R8: A `start` sampled while idle raises `busy` in the next cycle. `done` is a single-cycle pulse, and `busy` is already low when it appears. The result outputs stay stable from one `done` pulse to the next.
- R9: A `start` pulse while `busy` is high has no effect. The running search keeps the frequencies captured at its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (sampled only while idle) |
| ref_hz | input | FREQ_W | Reference frequency, captured at start |
| target_hz | input | FREQ_W | Wanted output frequency, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| best_mul | output | MUL_W | Chosen multiplier |
| best_div | output | DIV_W | Chosen divider (1-based) |
| best_err | output | FREQ_W | Residual error of the chosen pair |
| cfg_word | output | MUL_W+8 | Packed configuration word |

## Verification
On every cycle, the assertions check the handshake: `done` lasts one cycle and never coincides with `busy`, `busy` only rises after `start` and only ends through `done`, and the results stay still between pulses. Each time `done` fires, they also check that the divider and multiplier are in range and that the packed word matches its fields. Whether the chosen pair is correct can only be shown by the bench scenarios. These cover strict-improvement tie-breaking, early exit on an exact hit (seen as a shorter busy time), the fallback when nothing improves, the extreme multiplier and divider, products wider than the frequency field, and a start pulse issued mid-search.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_SCAN,
    ST_FIN
  } search_state_t;

  // bit position of the multiplier field in the packed word
  localparam int unsigned CFG_MUL_LSB = 8;

endpackage

// File: rtl/pll_quot_div.sv
// Sequential restoring divider: one quotient bit per clock.
module pll_quot_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         valid,
  output logic [W-1:0] quotient
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  logic [W:0] shifted;
  logic       fits;

  assign shifted  = {rem_q, quo_q[W-1]};
  assign fits     = shifted >= {1'b0, dsr_q};
  assign quotient = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? W'(shifted - {1'b0, dsr_q}) : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pll_quot_ram.sv
// Simple dual-port memory with registered read, block-RAM friendly.
module pll_quot_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pll_cand_score.sv
// Scores one candidate per clock and keeps the first strictly better one.
module pll_cand_score #(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned MUL_W  = 11,
  parameter int unsigned DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic [FREQ_W-1:0] target,
  input  logic              in_vld,
  input  logic [MUL_W-1:0]  in_mul,
  input  logic [DIV_W-1:0]  in_div,
  input  logic [FREQ_W-1:0] in_quot,
  output logic              hit,
  output logic [MUL_W-1:0]  best_mul,
  output logic [DIV_W-1:0]  best_div,
  output logic [FREQ_W-1:0] best_err
);

  localparam int unsigned PW = FREQ_W + MUL_W;

  logic [PW-1:0] prod;
  logic [PW-1:0] tgt_w;
  logic [PW-1:0] err;
  logic          better;

  assign prod   = PW'(in_mul) * PW'(in_quot);
  assign tgt_w  = PW'(target);
  assign err    = (tgt_w >= prod) ? (tgt_w - prod) : (prod - tgt_w);
  assign better = in_vld && (err < PW'(best_err));
  assign hit    = in_vld && (err == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      best_mul <= MUL_W'(1);
      best_div <= DIV_W'(1);
      best_err <= '0;
    end else if (init) begin
      best_mul <= MUL_W'(1);
      best_div <= DIV_W'(1);
      best_err <= target;
    end else if (better) begin
      best_mul <= in_mul;
      best_div <= in_div;
      best_err <= err[FREQ_W-1:0];
    end
  end

endmodule

// File: rtl/pll_ratio_search.sv
module pll_ratio_search
  import pll_search_pkg::*;
#(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned MUL_W  = 11,
  parameter int unsigned DIV_W  = 7
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [FREQ_W-1:0]                  ref_hz,
  input  logic [FREQ_W-1:0]                  target_hz,
  output logic                               busy,
  output logic                               done,
  output logic [MUL_W-1:0]                   best_mul,
  output logic [DIV_W-1:0]                   best_div,
  output logic [FREQ_W-1:0]                  best_err,
  output logic [MUL_W+CFG_MUL_LSB-1:0]       cfg_word
);

  localparam int unsigned CFG_W = MUL_W + CFG_MUL_LSB;
  localparam logic [MUL_W-1:0] MAX_MUL = '1;
  localparam logic [DIV_W-1:0] MAX_DIV = '1;

  search_state_t state_q;

  logic [FREQ_W-1:0] ref_q;
  logic [FREQ_W-1:0] tgt_q;
  logic [DIV_W-1:0]  prep_div_q;

  logic [MUL_W-1:0]  scan_mul_q;
  logic [DIV_W-1:0]  scan_div_q;
  logic              all_issued_q;

  logic              p_vld_q;
  logic              p_last_q;
  logic [MUL_W-1:0]  p_mul_q;
  logic [DIV_W-1:0]  p_div_q;

  // divider handshake
  logic              q_go;
  logic [FREQ_W-1:0] q_dividend;
  logic [FREQ_W-1:0] q_divisor;
  logic              q_valid;
  logic [FREQ_W-1:0] q_value;

  logic              launch;
  logic              prep_last;
  logic              issue;
  logic              finish;
  logic              score_init;
  logic              hit;
  logic [FREQ_W-1:0] ram_rdata;
  logic [MUL_W-1:0]  sc_mul;
  logic [DIV_W-1:0]  sc_div;
  logic [FREQ_W-1:0] sc_err;

  assign launch     = (state_q == ST_IDLE) && start;
  assign prep_last  = (state_q == ST_PREP) && q_valid && (prep_div_q == MAX_DIV);
  assign q_go       = launch || ((state_q == ST_PREP) && q_valid && (prep_div_q != MAX_DIV));
  assign q_dividend = launch ? ref_hz : ref_q;
  assign q_divisor  = launch ? FREQ_W'(1) : FREQ_W'(prep_div_q + DIV_W'(1));
  assign score_init = prep_last;
  assign issue      = (state_q == ST_SCAN) && !all_issued_q && !hit;
  assign finish     = (state_q == ST_SCAN) && (hit || (p_vld_q && p_last_q));
  assign busy       = (state_q != ST_IDLE);

  pll_quot_div #(
    .W (FREQ_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (q_go),
    .dividend (q_dividend),
    .divisor  (q_divisor),
    .valid    (q_valid),
    .quotient (q_value)
  );

  pll_quot_ram #(
    .AW (DIV_W),
    .DW (FREQ_W)
  ) u_ram (
    .clk   (clk),
    .we    ((state_q == ST_PREP) && q_valid),
    .waddr (prep_div_q),
    .wdata (q_value),
    .raddr (scan_div_q),
    .rdata (ram_rdata)
  );

  pll_cand_score #(
    .FREQ_W (FREQ_W),
    .MUL_W  (MUL_W),
    .DIV_W  (DIV_W)
  ) u_score (
    .clk      (clk),
    .rst      (rst),
    .init     (score_init),
    .target   (tgt_q),
    .in_vld   (p_vld_q),
    .in_mul   (p_mul_q),
    .in_div   (p_div_q),
    .in_quot  (ram_rdata),
    .hit      (hit),
    .best_mul (sc_mul),
    .best_div (sc_div),
    .best_err (sc_err)
  );

  // control state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ref_q      <= '0;
      tgt_q      <= '0;
      prep_div_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ref_q      <= ref_hz;
            tgt_q      <= target_hz;
            prep_div_q <= DIV_W'(1);
            state_q    <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (q_valid) begin
            if (prep_div_q == MAX_DIV) state_q <= ST_SCAN;
            else prep_div_q <= prep_div_q + DIV_W'(1);
          end
        end
        ST_SCAN: begin
          if (finish) state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // candidate issue counters: multiplier outer, divider inner
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_mul_q   <= MUL_W'(1);
      scan_div_q   <= DIV_W'(1);
      all_issued_q <= 1'b0;
    end else if (prep_last) begin
      scan_mul_q   <= MUL_W'(1);
      scan_div_q   <= DIV_W'(1);
      all_issued_q <= 1'b0;
    end else if (issue) begin
      if (scan_div_q == MAX_DIV) begin
        scan_div_q <= DIV_W'(1);
        if (scan_mul_q == MAX_MUL) all_issued_q <= 1'b1;
        else scan_mul_q <= scan_mul_q + MUL_W'(1);
      end else begin
        scan_div_q <= scan_div_q + DIV_W'(1);
      end
    end
  end

  // one stage that lines the tags up with the memory read
  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld_q  <= 1'b0;
      p_last_q <= 1'b0;
      p_mul_q  <= '0;
      p_div_q  <= '0;
    end else begin
      p_vld_q  <= issue;
      p_last_q <= issue && (scan_mul_q == MAX_MUL) && (scan_div_q == MAX_DIV);
      p_mul_q  <= scan_mul_q;
      p_div_q  <= scan_div_q;
    end
  end

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      best_mul <= MUL_W'(1);
      best_div <= DIV_W'(1);
      best_err <= '0;
      cfg_word <= CFG_W'(1) << CFG_MUL_LSB;
    end else begin
      done <= 1'b0;
      if (state_q == ST_FIN) begin
        done     <= 1'b1;
        best_mul <= sc_mul;
        best_div <= sc_div;
        best_err <= sc_err;
        cfg_word <= (CFG_W'(sc_mul) << CFG_MUL_LSB) | CFG_W'(sc_div - DIV_W'(1));
      end
    end
  end

endmodule

// File: rtl/pll_ratio_search_chk.sv
module pll_ratio_search_chk #(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned MUL_W  = 11,
  parameter int unsigned DIV_W  = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [MUL_W-1:0]     best_mul,
  input logic [DIV_W-1:0]     best_div,
  input logic [FREQ_W-1:0]    best_err,
  input logic [MUL_W+8-1:0]   cfg_word
);

  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(busy)) |-> $past(start));

  assert_busy_ends_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  assert_results_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !done) |-> ($stable(cfg_word) && $stable(best_err)
                            && $stable(best_mul) && $stable(best_div)));

  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (best_mul != '0) && (best_div != '0));

  assert_pack_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ((cfg_word >> 8) == (MUL_W+8)'(best_mul))
             && (cfg_word[7:0] == (8'(best_div) - 8'd1)));

endmodule

bind pll_ratio_search pll_ratio_search_chk #(
  .FREQ_W (FREQ_W),
  .MUL_W  (MUL_W),
  .DIV_W  (DIV_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .best_mul (best_mul),
  .best_div (best_div),
  .best_err (best_err),
  .cfg_word (cfg_word)
);

// File: tb/test_pll_ratio_search.sv
module test_pll_ratio_search;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W = 20;
  localparam int MUL_W  = 6;
  localparam int DIV_W  = 4;
  localparam int MAXM   = (1 << MUL_W) - 1;
  localparam int MAXD   = (1 << DIV_W) - 1;
  localparam int CFG_W  = MUL_W + 8;
  localparam int WAIT_LIMIT = 5000;
  localparam int WDOG_LIMIT = 190000;

  // stimulus and expected result vectors
  localparam int NV = 9;
  localparam int    V_REF [NV] = '{1000, 1000, 1000, 1000, 0,  7,   2,   10,  210};
  localparam int    V_TGT [NV] = '{1000, 3000, 500,  0,    50, 100, 101, 700, 14};
  localparam int    V_MUL [NV] = '{1,    3,    1,    1,    1,  50,  50,  63,  1};
  localparam int    V_DIV [NV] = '{1,    1,    2,    1,    1,  3,   1,   1,   15};
  localparam int    V_ERR [NV] = '{0,    0,    0,    0,    50, 0,   1,   70,  0};
  localparam string V_TAG [NV] = '{"R5", "R5", "R4", "R6", "R6", "R5", "R4", "R2", "R2"};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [FREQ_W-1:0] ref_hz = '0;
  logic [FREQ_W-1:0] target_hz = '0;
  logic              busy;
  logic              done;
  logic [MUL_W-1:0]  best_mul;
  logic [DIV_W-1:0]  best_div;
  logic [FREQ_W-1:0] best_err;
  logic [CFG_W-1:0]  cfg_word;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_ratio_search #(
    .FREQ_W (FREQ_W),
    .MUL_W  (MUL_W),
    .DIV_W  (DIV_W)
  ) i_pll_ratio_search (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ref_hz    (ref_hz),
    .target_hz (target_hz),
    .busy      (busy),
    .done      (done),
    .best_mul  (best_mul),
    .best_div  (best_div),
    .best_err  (best_err),
    .cfg_word  (cfg_word)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp<%0d", cycles, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // reference search written from the requirements
  task automatic model(input longint r, input longint t,
                       output int m_o, output int d_o, output longint e_o);
    longint best;
    bit stop;
    best = t; m_o = 1; d_o = 1; stop = 0;
    for (int m = 1; m <= MAXM && !stop; m++) begin
      for (int d = 1; d <= MAXD && !stop; d++) begin
        longint p, e;
        p = m * (r / d);
        e = (t >= p) ? t - p : p - t;
        if (e < best) begin best = e; m_o = m; d_o = d; end
        if (e == 0) stop = 1;
      end
    end
    e_o = best;
  endtask

  task automatic run(input int r, input int t, output int cyc);
    @(negedge clk);
    ref_hz = FREQ_W'(r);
    target_hz = FREQ_W'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < WAIT_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk("R8", "done timeout", 0, 1);
  endtask

  task automatic check_result(input string tag, input int m, input int d, input int e);
    chk(tag, "mul", best_mul, m);
    chk(tag, "div", best_div, d);
    chk(tag, "err", best_err, e);
    chk("R7", "cfg", cfg_word, (m << 8) | (d - 1));
  endtask

  initial begin
    int cyc, cyc_early, cyc_full, m, d;
    longint e;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mul", best_mul, 1);
    chk("R1", "div", best_div, 1);
    chk("R1", "err", best_err, 0);
    chk("R1", "cfg", cfg_word, 256);

    // vector table
    for (int i = 0; i < NV; i++) begin
      run(V_REF[i], V_TGT[i], cyc);
      check_result(V_TAG[i], V_MUL[i], V_DIV[i], V_ERR[i]);
    end

    // R8 handshake timing and holding of results
    @(negedge clk);
    ref_hz = FREQ_W'(1000);
    target_hz = FREQ_W'(3000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "busy after start", busy, 1);
    chk("R8", "done during run", done, 0);
    cyc = 0;
    while (!done && cyc < WAIT_LIMIT) begin @(negedge clk); cyc++; end
    chk("R8", "busy at done", busy, 0);
    @(negedge clk);
    chk("R8", "done width", done, 0);
    ref_hz = FREQ_W'(7);
    target_hz = FREQ_W'(100);
    repeat (5) @(negedge clk);
    chk("R8", "cfg held", cfg_word, (3 << 8));
    chk("R8", "err held", best_err, 0);

    // R9 start while busy is ignored, captured inputs are kept
    @(negedge clk);
    ref_hz = FREQ_W'(1000);
    target_hz = FREQ_W'(3000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    ref_hz = FREQ_W'(7);
    target_hz = FREQ_W'(100);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < WAIT_LIMIT) begin @(negedge clk); cyc++; end
    check_result("R9", 3, 1, 0);
    @(negedge clk);
    chk("R9", "no second run", busy, 0);

    // R5 early termination: exact hit on the first candidate vs full scan
    run(1000, 1000, cyc_early);
    run(1000, 0, cyc_full);
    chk("R5", "cycles saved", cyc_full - cyc_early, MAXM * MAXD - 1);

    // R3 products wider than the frequency field
    model(600000, 1048575, m, d, e);
    run(600000, 1048575, cyc);
    check_result("R3", m, d, int'(e));

    // R4 model cross-check on another pattern
    model(123457, 999999, m, d, e);
    run(123457, 999999, cyc);
    check_result("R4", m, d, int'(e));

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule